// File: doc/BRIEF.md
# Sixteen-Channel Output Code Update Controller

This block keeps one data register per output channel for sixteen converter channels and decides in which cycle each channel's active output code takes a new value. A host drives single-cycle register writes (address plus 16-bit data) and combinational reads. A separate one-cycle load pulse can also be driven from a pin. Each channel is set up on its own to follow its data register at once, or to hold its active code until a load event. A load event updates all deferred channels in the same cycle.

Channels are grouped in adjacent pairs, and a pair can be marked as differential. The controller then accepts data only for the even channel of the pair. A masked broadcast write copies one value into a selected set of channels, but only while no pair is differential. A keyed command on the trigger address returns every register to its reset value.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, the sync-mode word (06h) reads 0000h, the broadcast mask (05h) reads FFFFh, the pair word (04h) reads 0000h, the broadcast data (0Fh) and every channel data register (10h+i) read 0000h, and every active code is 0000h.
- R2: Channel i's data register is at address 10h+i, and its active code is `active_code[16*i+15:16*i]`. When bit i of 06h is 0, a write to 10h+i makes that value the active code from the first clock edge that samples the write.
- R3: When bit i of 06h is 1, a data write leaves channel i's active code unchanged. Either a pulse on `ldac_pulse` or a write to 0Eh with bit 4 set loads every such channel's data register into its active code on that edge. A data write in the same cycle as the load is not part of that load; the value held before the write is the one loaded.
- R4: A write to 0Fh, while 04h bits are all 0, stores the value in the data register of every channel whose bit in 05h is 1. Those channels then update as in R2 or R3, and channels whose mask bit is 0 are unchanged. The last value written is read back at 0Fh.
- R5: While any bit of 04h[7:0] is 1, a write to 0Fh changes no channel data register and no active code, but the value is still read back at 0Fh.
- R6: Bit k of 04h (k = 0..7) marks channels 2k and 2k+1 as a differential pair. While it is set, writes to 10h+2k+1 are dropped, and writes to 10h+2k behave as in R2/R3. Only bits 7:0 of 04h are stored; the upper bits read 0.
- R7: A write to 0Eh whose bits 3:0 equal 1010b returns all registers and active codes to their R1 values on that edge, even if bit 4 is also set. Any other value in bits 3:0 causes no reset.
- R8: Address 0Eh and every address other than 04h, 05h, 06h, 0Fh and 10h..1Fh read 0000h, and writes to the unlisted addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Combinational read data |
| ldac_pulse | input | 1 | One-cycle load trigger for deferred channels |
| active_code | output | 256 | Active codes, channel i in bits 16*i+15:16*i |

## Verification
The outputs show a wrong per-channel mode bit one clock after the next data write to that channel: the active code either moves when it should hold, or holds when it should move. A stale data register stays hidden until a load event, and then appears as a wrong active code on the edge of that load. A wrong pair or mask bit shows at once as a wrong read-back of a dropped or broadcast target, so the tests follow each write with both a read and an active-code check.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int unsigned AW = 6;
  localparam logic [AW-1:0] A_PAIRCFG = 6'h04;
  localparam logic [AW-1:0] A_BMASK   = 6'h05;
  localparam logic [AW-1:0] A_SYNC    = 6'h06;
  localparam logic [AW-1:0] A_TRIG    = 6'h0E;
  localparam logic [AW-1:0] A_BDATA   = 6'h0F;
  localparam logic [AW-1:0] A_CHBASE  = 6'h10;
  localparam int unsigned   TRIG_LOAD_BIT = 4;
  localparam logic [3:0]    RESET_KEY = 4'b1010;
endpackage

// File: rtl/dacu_cfg_regs.sv
module dacu_cfg_regs #(
  parameter int unsigned CH_N = 16,
  parameter int unsigned DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [dacu_pkg::AW-1:0] wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ldac_pin,
  output logic [CH_N/2-1:0]       pair_q,
  output logic [CH_N-1:0]         sync_q,
  output logic [CH_N-1:0]         bmask_q,
  output logic [DW-1:0]           bdata_q,
  output logic                    soft_rst,
  output logic                    load_fire,
  output logic                    bcast_fire
);
  import dacu_pkg::*;
  localparam int unsigned PAIR_N = CH_N / 2;

  logic              trig_wr, bdata_wr;
  logic [PAIR_N-1:0] pair_d;
  logic [CH_N-1:0]   sync_d, bmask_d;
  logic [DW-1:0]     bdata_d;
  logic              pair_en, sync_en, bmask_en, bdata_en;

  always_comb begin
    trig_wr    = wr_en && (wr_addr == A_TRIG);
    bdata_wr   = wr_en && (wr_addr == A_BDATA);
    soft_rst   = trig_wr && (wr_data[3:0] == RESET_KEY);
    load_fire  = (ldac_pin || (trig_wr && wr_data[TRIG_LOAD_BIT])) && !soft_rst;
    bcast_fire = bdata_wr && (pair_q == '0);

    pair_en  = soft_rst || (wr_en && (wr_addr == A_PAIRCFG));
    sync_en  = soft_rst || (wr_en && (wr_addr == A_SYNC));
    bmask_en = soft_rst || (wr_en && (wr_addr == A_BMASK));
    bdata_en = soft_rst || bdata_wr;

    pair_d  = soft_rst ? '0 : wr_data[PAIR_N-1:0];
    sync_d  = soft_rst ? '0 : wr_data[CH_N-1:0];
    bmask_d = soft_rst ? '1 : wr_data[CH_N-1:0];
    bdata_d = soft_rst ? '0 : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q  <= '0;
      sync_q  <= '0;
      bmask_q <= '1;
      bdata_q <= '0;
    end else begin
      if (pair_en)  pair_q  <= pair_d;
      if (sync_en)  sync_q  <= sync_d;
      if (bmask_en) bmask_q <= bmask_d;
      if (bdata_en) bdata_q <= bdata_d;
    end
  end

  assert_cfg_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sync_q == '0) && (bmask_q == '1) && (pair_q == '0) && (bdata_q == '0));

  assert_bdata_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bdata_wr && (pair_q != '0)) |=> (bdata_q == $past(wr_data)));
endmodule

// File: rtl/dacu_chan.sv
module dacu_chan #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  input  logic          sync_mode,
  input  logic          load_fire,
  input  logic          soft_rst,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] active_q
);
  logic [DW-1:0] data_d, active_d;
  logic          data_en, active_en;

  always_comb begin
    data_en   = soft_rst || load;
    data_d    = soft_rst ? '0 : wdata;
    active_en = soft_rst || (sync_mode ? load_fire : load);
    if (soft_rst)       active_d = '0;
    else if (sync_mode) active_d = data_q;
    else                active_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      active_q <= '0;
    end else begin
      if (data_en)   data_q   <= data_d;
      if (active_en) active_q <= active_d;
    end
  end

  assert_immediate_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !sync_mode && !soft_rst) |=> (active_q == data_q));

  assert_deferred_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !load_fire && !soft_rst) |=> $stable(active_q));

  assert_deferred_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && load_fire && !soft_rst) |=> (active_q == $past(data_q)));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int unsigned CH_N = 16,
  parameter int unsigned DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [dacu_pkg::AW-1:0] wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [dacu_pkg::AW-1:0] rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic                    ldac_pulse,
  output logic [CH_N*DW-1:0]      active_code
);
  import dacu_pkg::*;
  localparam int unsigned PAIR_N = CH_N / 2;
  localparam int unsigned CIDX_W = (CH_N > 1) ? $clog2(CH_N) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [PAIR_N-1:0] pair_q;
  logic [CH_N-1:0]   sync_q, bmask_q;
  logic [DW-1:0]     bdata_q;
  logic              soft_rst, load_fire, bcast_fire;
  logic [DW-1:0]     chan_data [CH_N];
  logic [CH_N*DW-1:0] data_flat;
  logic [CH_N-1:0]   wr_hit;
  logic [AW-1:0]     rd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dacu_cfg_regs #(.CH_N(CH_N), .DW(DW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ldac_pin   (ldac_pulse),
    .pair_q     (pair_q),
    .sync_q     (sync_q),
    .bmask_q    (bmask_q),
    .bdata_q    (bdata_q),
    .soft_rst   (soft_rst),
    .load_fire  (load_fire),
    .bcast_fire (bcast_fire)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic blocked;
    if (i % 2 == 1) begin : g_upper
      assign blocked = pair_q[i/2];
    end else begin : g_lower
      assign blocked = 1'b0;
    end
    assign wr_hit[i] = wr_en && (wr_addr == AW'(A_CHBASE + i)) && !blocked;

    dacu_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .load      (wr_hit[i] || (bcast_fire && bmask_q[i])),
      .wdata     (wr_data),
      .sync_mode (sync_q[i]),
      .load_fire (load_fire),
      .soft_rst  (soft_rst),
      .data_q    (chan_data[i]),
      .active_q  (active_code[i*DW +: DW])
    );
    assign data_flat[i*DW +: DW] = chan_data[i];

    if (i % 2 == 1) begin : g_drop_chk
      assert_upper_dropped_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
        (wr_en && (wr_addr == AW'(A_CHBASE + i)) && pair_q[i/2]) |=> $stable(chan_data[i]));
    end
  end

  always_comb begin
    rd_off  = rd_addr - A_CHBASE;
    rd_data = '0;
    if ((rd_addr >= A_CHBASE) && (rd_addr < AW'(A_CHBASE + CH_N)))
      rd_data = chan_data[rd_off[CIDX_W-1:0]];
    else if (rd_addr == A_PAIRCFG) rd_data = DW'(pair_q);
    else if (rd_addr == A_BMASK)   rd_data = DW'(bmask_q);
    else if (rd_addr == A_SYNC)    rd_data = DW'(sync_q);
    else if (rd_addr == A_BDATA)   rd_data = bdata_q;
  end

  assert_bcast_blocked_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && (wr_addr == A_BDATA) && (pair_q != '0)) |=> $stable(data_flat));

  assert_reset_codes_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    soft_rst |=> (active_code == '0) && (data_flat == '0));
endmodule

// File: tb/dac_update_ctrl_bench.sv
module dac_update_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [5:0]   wr_addr;
  logic [15:0]  wr_data;
  logic [5:0]   rd_addr;
  logic [15:0]  rd_data;
  logic         ldac_pulse;
  logic [255:0] active_code;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_update_ctrl u_dac_update_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ldac_pulse(ldac_pulse), .active_code(active_code)
  );

  function automatic logic [15:0] act(input int ch);
    return active_code[ch*16 +: 16];
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic hw_reset();
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; ldac_pulse = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input bit with_load = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; ldac_pulse = with_load;
    @(negedge clk);
    wr_en = 0; ldac_pulse = 0;
  endtask

  task automatic pulse_load();
    @(negedge clk);
    ldac_pulse = 1;
    @(negedge clk);
    ldac_pulse = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic check_rd(input string req, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, $sformatf("read %h", a), v, exp);
  endtask

  task automatic t_reset();
    hw_reset();
    check_rd("R1", 6'h06, 16'h0000);
    check_rd("R1", 6'h05, 16'hFFFF);
    check_rd("R1", 6'h04, 16'h0000);
    check_rd("R1", 6'h0F, 16'h0000);
    check_rd("R1", 6'h17, 16'h0000);
    for (int i = 0; i < 16; i++) check("R1", $sformatf("active %0d", i), act(i), 16'h0000);
  endtask

  task automatic t_async();
    hw_reset();
    wr(6'h13, 16'hA5A5);
    check("R2", "active 3", act(3), 16'hA5A5);
    check_rd("R2", 6'h13, 16'hA5A5);
    check("R2", "active 2 untouched", act(2), 16'h0000);
    wr(6'h1F, 16'hFFFF);
    check("R2", "active 15", act(15), 16'hFFFF);
    wr(6'h10, 16'h0001);
    check("R2", "active 0", act(0), 16'h0001);
  endtask

  task automatic t_sync();
    hw_reset();
    wr(6'h06, 16'h0011);
    wr(6'h10, 16'h1234);
    check("R3", "ch0 held", act(0), 16'h0000);
    wr(6'h14, 16'h5678);
    check("R3", "ch4 held", act(4), 16'h0000);
    wr(6'h11, 16'h0042);
    check("R3", "ch1 immediate", act(1), 16'h0042);
    pulse_load();
    check("R3", "ch0 pin load", act(0), 16'h1234);
    check("R3", "ch4 pin load", act(4), 16'h5678);
    wr(6'h10, 16'h9999);
    wr(6'h0E, 16'h0010);
    check("R3", "ch0 trigger load", act(0), 16'h9999);
    check("R3", "ch1 not affected", act(1), 16'h0042);
    wr(6'h14, 16'hAAAA, 1);
    check("R3", "ch4 concurrent keeps old", act(4), 16'h5678);
    pulse_load();
    check("R3", "ch4 later load", act(4), 16'hAAAA);
    check_rd("R8", 6'h0E, 16'h0000);
  endtask

  task automatic t_bcast();
    hw_reset();
    wr(6'h05, 16'h8005);
    wr(6'h06, 16'h0004);
    wr(6'h0F, 16'hBEEF);
    check("R4", "ch0", act(0), 16'hBEEF);
    check("R4", "ch15", act(15), 16'hBEEF);
    check("R4", "ch1 masked", act(1), 16'h0000);
    check_rd("R4", 6'h11, 16'h0000);
    check("R4", "ch2 deferred", act(2), 16'h0000);
    check_rd("R4", 6'h12, 16'hBEEF);
    check_rd("R4", 6'h0F, 16'hBEEF);
    pulse_load();
    check("R4", "ch2 after load", act(2), 16'hBEEF);
  endtask

  task automatic t_pairs();
    hw_reset();
    wr(6'h04, 16'h0081);
    check_rd("R6", 6'h04, 16'h0081);
    wr(6'h11, 16'h1111);
    check("R6", "ch1 dropped", act(1), 16'h0000);
    check_rd("R6", 6'h11, 16'h0000);
    wr(6'h10, 16'h2222);
    check("R6", "ch0 accepted", act(0), 16'h2222);
    wr(6'h1F, 16'h3333);
    check("R6", "ch15 dropped", act(15), 16'h0000);
    wr(6'h1E, 16'h3030);
    check("R6", "ch14 accepted", act(14), 16'h3030);
    wr(6'h13, 16'h4444);
    check("R6", "ch3 non-pair", act(3), 16'h4444);
    wr(6'h0F, 16'h7777);
    check("R5", "ch0 unchanged", act(0), 16'h2222);
    check("R5", "ch5 unchanged", act(5), 16'h0000);
    check_rd("R5", 6'h15, 16'h0000);
    check_rd("R5", 6'h0F, 16'h7777);
    wr(6'h04, 16'hFF81);
    check_rd("R6", 6'h04, 16'h0081);
  endtask

  task automatic t_soft_reset();
    hw_reset();
    wr(6'h06, 16'h00F0);
    wr(6'h05, 16'h00FF);
    wr(6'h04, 16'h0001);
    wr(6'h12, 16'h1357);
    wr(6'h0F, 16'h2468);
    wr(6'h0E, 16'h000B);
    check_rd("R7", 6'h06, 16'h00F0);
    check("R7", "ch2 kept on wrong key", act(2), 16'h1357);
    wr(6'h0E, 16'h001A);
    check_rd("R7", 6'h06, 16'h0000);
    check_rd("R7", 6'h05, 16'hFFFF);
    check_rd("R7", 6'h04, 16'h0000);
    check_rd("R7", 6'h0F, 16'h0000);
    check_rd("R7", 6'h12, 16'h0000);
    check("R7", "ch2 cleared", act(2), 16'h0000);
  endtask

  task automatic t_reserved();
    hw_reset();
    wr(6'h00, 16'hFFFF);
    wr(6'h03, 16'hFFFF);
    wr(6'h24, 16'hFFFF);
    wr(6'h3F, 16'h1234);
    check_rd("R8", 6'h00, 16'h0000);
    check_rd("R8", 6'h03, 16'h0000);
    check_rd("R8", 6'h24, 16'h0000);
    check_rd("R8", 6'h05, 16'hFFFF);
    check_rd("R8", 6'h06, 16'h0000);
    check_rd("R8", 6'h04, 16'h0000);
    for (int i = 0; i < 16; i++) check("R8", $sformatf("active %0d", i), act(i), 16'h0000);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_async();
    t_sync();
    t_bcast();
    t_pairs();
    t_soft_reset();
    t_reserved();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule